// File: doc/BRIEF.md
# Bus-Based Two's-Complement Subtractor

This block takes two unsigned operands from one shared input port, one after the other, and returns their difference modulo 2^W. Three working registers sit around an eight-function ALU. Two operand buses, X and Y, feed the ALU inputs. The ALU result bus Z feeds back to every register and goes out to the output port.

A Moore controller runs a fixed four-step program:
1. Load the minuend from the input through the Y bus.
2. Load the subtrahend the same way.
3. Add the minuend to the inverted subtrahend with carry-in set, and store the sum in the third register.
4. Replay that register onto the output for one cycle while raising a done flag.

The buses are multiplexers driven by one-hot source enables. A bus with no source enabled reads as zero.

The environment starts a run with a one-cycle start pulse while the block is idle. It watches the input-request output: the value on `din` in the first request cycle becomes the minuend, and the value in the second request cycle becomes the subtrahend. The difference appears on `dout` while `done` is high. The carry out of the subtraction, which is 1 when no borrow occurred, is held on `no_borrow` until the next result is stored.

Top module: `twos_sub_sys`

## Requirements
- R1: While reset is asserted, and after it is released until a start is accepted, `ext_in_req`, `done` and `dout` are all 0.
- R2: A high `start` sampled while idle makes `ext_in_req` high for exactly two consecutive cycles, beginning in the cycle after the sampling edge.
- R3: The `din` value in the first request cycle is the minuend A. The `din` value in the second request cycle is the subtrahend B.
- R4: `done` is high for exactly one cycle. That cycle is the second cycle after the last request cycle.
- R5: While `done` is high, `dout` equals (A − B) mod 2^W, with A and B read as unsigned.
- R6: Whenever `done` is low, `dout` is 0.
- R7: From the `done` cycle until the next result is stored, `no_borrow` equals 1 when A ≥ B (unsigned) and 0 otherwise.
- R8: `start` has no effect while a run is in progress. After `done`, the block returns to idle, and `ext_in_req` stays low unless a new start is sampled.
- R9: `din` has no effect outside request cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only when idle |
| din | input | W | Operand data; read only in request cycles |
| ext_in_req | output | 1 | High while the block is reading an operand from `din` |
| dout | output | W | The difference while `done` is high; 0 otherwise |
| done | output | 1 | One-cycle flag marking a valid result on `dout` |
| no_borrow | output | 1 | Carry out of the last subtraction (1 means A ≥ B) |

## Verification
The hardest condition to reach from the ports is a `start` pulse or a changing `din` that arrives while the sequence is in its compute or output step. In that window the controller must ignore both inputs.

The driver deliberately pulses `start` during the compute cycle and drives junk values on `din` outside the two request cycles. The scoreboard then confirms three things: the result is unchanged, `done` occurs once, and no new request follows.

Operand pairs cover the following cases:
- values below 8;
- values above 8;
- a subtrahend larger than the minuend, which forces a borrow;
- the all-zero and all-ones extremes.

// File: rtl/twos_sub_pkg.sv
package twos_sub_pkg;

  localparam int NREG = 3;

  typedef enum logic [2:0] {
    FN_NOP  = 3'b000,
    FN_PX   = 3'b001,
    FN_PY   = 3'b010,
    FN_ADD  = 3'b011,
    FN_SUBC = 3'b100,
    FN_AND  = 3'b101,
    FN_OR   = 3'b110,
    FN_XOR  = 3'b111
  } alu_fn_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET_A,
    ST_GET_B,
    ST_CALC,
    ST_SHOW
  } seq_st_e;

  typedef struct packed {
    logic [NREG-1:0] ld;
    logic [NREG-1:0] x_en;
    logic [NREG-1:0] y_en;
    logic            ext_in;
    logic            ext_out;
    alu_fn_e         fn;
    logic            cin;
  } ctl_t;

endpackage

// File: rtl/twos_sub_alu.sv
module twos_sub_alu
  import twos_sub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] z_o,
  output logic         cout_o
);

  logic [W:0] add_w;
  logic [W:0] sub_w;

  assign add_w = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
  assign sub_w = {1'b0, x_i} + {1'b0, ~y_i} + {{W{1'b0}}, cin_i};

  always_comb begin
    z_o    = '0;
    cout_o = 1'b0;
    unique case (fn_i)
      FN_NOP:  z_o = '0;
      FN_PX:   z_o = x_i;
      FN_PY:   z_o = y_i;
      FN_ADD:  begin z_o = add_w[W-1:0]; cout_o = add_w[W]; end
      FN_SUBC: begin z_o = sub_w[W-1:0]; cout_o = sub_w[W]; end
      FN_AND:  z_o = x_i & y_i;
      FN_OR:   z_o = x_i | y_i;
      FN_XOR:  z_o = x_i ^ y_i;
      default: z_o = '0;
    endcase
  end

endmodule

// File: rtl/twos_sub_path.sv
module twos_sub_path
  import twos_sub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctl_t         ctl_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         nb_o
);

  logic [W-1:0] r_q [NREG];
  logic [W-1:0] xs  [NREG+1];
  logic [W-1:0] ys  [NREG+2];
  logic [W-1:0] x_bus;
  logic [W-1:0] y_bus;
  logic [W-1:0] z_bus;
  logic         cout;
  logic         nb_q;

  assign xs[0] = '0;
  assign ys[0] = '0;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q[i] <= '0;
      end else if (ctl_i.ld[i]) begin
        r_q[i] <= z_bus;
      end
    end
    assign xs[i+1] = xs[i] | (r_q[i] & {W{ctl_i.x_en[i]}});
    assign ys[i+1] = ys[i] | (r_q[i] & {W{ctl_i.y_en[i]}});
  end

  assign ys[NREG+1] = ys[NREG] | (din_i & {W{ctl_i.ext_in}});
  assign x_bus      = xs[NREG];
  assign y_bus      = ys[NREG+1];

  twos_sub_alu #(.W(W)) alu_i (
    .x_i    (x_bus),
    .y_i    (y_bus),
    .cin_i  (ctl_i.cin),
    .fn_i   (ctl_i.fn),
    .z_o    (z_bus),
    .cout_o (cout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nb_q <= 1'b0;
    end else if (ctl_i.ld[NREG-1]) begin
      nb_q <= cout;
    end
  end

  assign dout_o = z_bus & {W{ctl_i.ext_out}};
  assign nb_o   = nb_q;

endmodule

// File: rtl/twos_sub_seq.sv
module twos_sub_seq
  import twos_sub_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output ctl_t ctl_o
);

  seq_st_e st_q;
  seq_st_e st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_GET_A;
      ST_GET_A: st_d = ST_GET_B;
      ST_GET_B: st_d = ST_CALC;
      ST_CALC:  st_d = ST_SHOW;
      ST_SHOW:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_comb begin
    ctl_o = '0;
    ctl_o.fn = FN_NOP;
    unique case (st_q)
      ST_GET_A: begin
        ctl_o.ext_in = 1'b1;
        ctl_o.fn     = FN_PY;
        ctl_o.ld[0]  = 1'b1;
      end
      ST_GET_B: begin
        ctl_o.ext_in = 1'b1;
        ctl_o.fn     = FN_PY;
        ctl_o.ld[1]  = 1'b1;
      end
      ST_CALC: begin
        ctl_o.x_en[0] = 1'b1;
        ctl_o.y_en[1] = 1'b1;
        ctl_o.fn      = FN_SUBC;
        ctl_o.cin     = 1'b1;
        ctl_o.ld[2]   = 1'b1;
      end
      ST_SHOW: begin
        ctl_o.x_en[2] = 1'b1;
        ctl_o.fn      = FN_PX;
        ctl_o.ext_out = 1'b1;
      end
      default: ctl_o.fn = FN_NOP;
    endcase
  end

endmodule

// File: rtl/twos_sub_sys.sv
module twos_sub_sys
  import twos_sub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] din,
  output logic         ext_in_req,
  output logic [W-1:0] dout,
  output logic         done,
  output logic         no_borrow
);

  ctl_t ctl;

  twos_sub_seq seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .ctl_o   (ctl)
  );

  twos_sub_path #(.W(W)) path_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_i  (ctl),
    .din_i  (din),
    .dout_o (dout),
    .nb_o   (no_borrow)
  );

  assign ext_in_req = ctl.ext_in;
  assign done       = ctl.ext_out;

endmodule

// File: rtl/twos_sub_chk.sv
module twos_sub_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ext_in_req,
  input logic         done,
  input logic [W-1:0] dout,
  input logic [2:0]   x_en,
  input logic [2:0]   y_en
);

  // R2
  req_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_in_req) |=> ext_in_req);

  // R2
  req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_in_req && $past(ext_in_req)) |=> !ext_in_req);

  // R4
  done_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_in_req) |=> done);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (dout == '0));

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && ext_in_req));

  // R5
  bus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(x_en) && $onehot0(y_en));

endmodule

bind twos_sub_sys twos_sub_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ext_in_req (ext_in_req),
  .done       (done),
  .dout       (dout),
  .x_en       (ctl.x_en),
  .y_en       (ctl.y_en)
);

// File: tb/twos_sub_sys_tb_top.sv
`timescale 1ns/1ps
module twos_sub_sys_tb_top;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] din;
  logic         ext_in_req;
  logic [W-1:0] dout;
  logic         done;
  logic         no_borrow;

  int errors = 0;
  int checks = 0;
  int done_seen = 0;
  int pushed = 0;
  logic [W:0] exp_q [$];

  twos_sub_sys #(.W(W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .din        (din),
    .ext_in_req (ext_in_req),
    .dout       (dout),
    .done       (done),
    .no_borrow  (no_borrow)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected result when done is high, checks silence otherwise
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        logic [W:0] e;
        done_seen++;
        if (exp_q.size() == 0) begin
          chk("R4 unexpected done", 32'd1, 32'd0);
        end else begin
          e = exp_q.pop_front();
          chk("R5 dout", 32'(dout), 32'(e[W-1:0]));
          chk("R7 no_borrow", 32'(no_borrow), 32'(e[W]));
        end
      end else if (dout !== '0) begin
        chk("R6 dout idle", 32'(dout), 32'd0);
      end
    end
  end

  task automatic run_case(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] e;
    e = {(a >= b), W'(a - b)};
    exp_q.push_back(e);
    pushed++;
    @(negedge clk);
    chk("R2 idle no req", 32'(ext_in_req), 32'd0);
    start = 1'b1;
    din   = ~a;
    @(negedge clk);
    start = 1'b0;
    chk("R2 req first", 32'(ext_in_req), 32'd1);
    din = a;
    @(negedge clk);
    chk("R2 req second", 32'(ext_in_req), 32'd1);
    din = b;
    @(negedge clk);
    chk("R2 req ends", 32'(ext_in_req), 32'd0);
    // R8, R9: stray start and junk data during compute
    start = 1'b1;
    din   = a ^ b ^ 8'h5A;
    @(negedge clk);
    start = 1'b0;
    chk("R4 done cycle", 32'(done), 32'd1);
    din = 8'hC3;
    @(negedge clk);
    chk("R4 done single", 32'(done), 32'd0);
    chk("R8 no restart", 32'(ext_in_req), 32'd0);
    chk("R7 no_borrow held", 32'(no_borrow), 32'(e[W]));
    @(negedge clk);
    chk("R8 still idle", 32'(ext_in_req), 32'd0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    din   = '0;
    #1;
    chk("R1 req in reset", 32'(ext_in_req), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 dout in reset", 32'(dout), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    din = 8'hFF;
    repeat (2) @(negedge clk);
    chk("R1 req after reset", 32'(ext_in_req), 32'd0);
    chk("R1 done after reset", 32'(done), 32'd0);
    chk("R1 nb after reset", 32'(no_borrow), 32'd0);
    // R3 operands below 8
    run_case(8'd5, 8'd3);
    run_case(8'd2, 8'd7);
    // operands above 8
    run_case(8'd200, 8'd9);
    run_case(8'd12, 8'd250);
    run_case(8'd128, 8'd127);
    run_case(8'd0, 8'd0);
    run_case(8'd255, 8'd255);
    run_case(8'd0, 8'd1);
    run_case(8'd255, 8'd0);
    for (int i = 0; i < 6; i++) begin
      run_case(W'((i * 37 + 11) % 256), W'((i * 91 + 200) % 256));
    end
    repeat (3) @(negedge clk);
    chk("R4 done count", 32'(done_seen), 32'(pushed));
    chk("R4 queue drained", 32'(exp_q.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule